// File: doc/BRIEF.md
# Floating-Point Exception Flag Controller

This block keeps the exception status that follows each floating-point operation. The arithmetic unit reports, for every operation it completes, a five-bit vector of the exceptions that operation raised. The controller compares that vector with a software-owned trap-enable register and splits it into two parts. Exceptions whose trap is disabled are recorded in a sticky accrued-flag register. Exceptions whose trap is enabled replace the contents of a separate actual-flag register, which therefore always describes only the most recent trapping event.

In the same cycle as the operation, the controller tells the pipeline whether the destination write must be suppressed. One cycle later it raises a trap request with a cause code for the trap sequencer. Only two pairs of exceptions may be raised together: overflow with inexact and underflow with inexact. When the overflow or underflow trap is enabled, it outranks inexact, and the inexact accrued flag is set as well. Software can load any of the three registers through a simple write port.

Top module: `fpx_flag_ctrl`

## Requirements
- R1: A raised exception whose enable bit is 0 sets its accrued bit on the clock edge that ends the operation cycle; no other accrued bit changes. The bit positions are inexact=0, underflow=1, overflow=2, divide-by-zero=3 and invalid=4, and they are the same in all three registers and in `op_exc`.
- R2: When a valid operation raises at least one enabled exception, the actual-flag register becomes one-hot on the reported exception after the edge, and all of its other bits are cleared.
- R3: `dest_wr_suppress` is high in the operation cycle itself exactly when `op_valid` is high and some raised exception has its enable bit set.
- R4: `op_exc` on a valid operation holds at most one bit, or exactly overflow+inexact, or exactly underflow+inexact.
- R5: When overflow or underflow is raised with inexact and its own trap is enabled, the trap reports overflow or underflow, the actual register holds only that bit, and accrued bit 0 (inexact) is set whether or not the inexact trap is enabled.
- R6: `trap_req` is high for the one cycle after a trapping operation, and `trap_cause` then gives the bit index plus one: 1 inexact, 2 underflow, 3 overflow, 4 divide-by-zero, 5 invalid. With no trap, both are 0.
- R7: A software write with `sw_wr_en` high loads `sw_wdata` into the register that `sw_sel` selects: 0 accrued, 1 actual, 2 enable, 3 none. A selection of 3 changes nothing. The write takes effect after the edge and wins over an operation update to the same register in that cycle.
- R8: A synchronous active-low reset clears the accrued, actual and enable registers, `trap_req` and `trap_cause`.
- R9: While `op_valid` is low, `op_exc` has no effect on any register or output.
- R10: A valid operation that raises no exception changes no register and requests no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation completes this cycle |
| op_exc | input | 5 | Exceptions raised by the completing operation |
| sw_wr_en | input | 1 | Software register write strobe |
| sw_sel | input | 2 | Write target: 0 accrued, 1 actual, 2 enable, 3 none |
| sw_wdata | input | 5 | Software write data |
| accrued_q | output | 5 | Sticky accrued-exception flags |
| actual_q | output | 5 | Flags of the latest trapping event |
| trap_en_q | output | 5 | Trap-enable register |
| dest_wr_suppress | output | 1 | Block the destination write (same cycle as operation) |
| trap_req | output | 1 | Trap request, one cycle after the operation |
| trap_cause | output | 3 | Code of the exception the trap reports |

## Verification
`dest_wr_suppress` is combinational and is due in the operation cycle itself. The bench therefore samples it one nanosecond after driving the inputs on the falling edge, before the next rising edge. The flag registers, `trap_req` and `trap_cause` are due after exactly one rising edge, so they are sampled on the following falling edge. At that point the operation inputs have already been withdrawn. A further falling-edge sample confirms that `trap_req` has dropped again, and register writes from software are checked on the same one-edge schedule.

// File: rtl/fpx_pkg.sv
// Package fpx_pkg
// Shared widths, flag bit positions, write-target codes and the
// legality rule for coincident exceptions. Assumes five exception kinds.
package fpx_pkg;
    localparam int NEXC    = 5;
    localparam int CAUSE_W = $clog2(NEXC + 1);
    localparam int SEL_W   = 2;

    localparam int IDX_INX = 0;
    localparam int IDX_UNF = 1;
    localparam int IDX_OVF = 2;
    localparam int IDX_DZ  = 3;
    localparam int IDX_INV = 4;

    typedef logic [NEXC-1:0] exc_vec_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_ACC  = 2'd0,
        SEL_ACT  = 2'd1,
        SEL_EN   = 2'd2,
        SEL_NONE = 2'd3
    } sw_sel_e;

    localparam exc_vec_t PAIR_OVF = exc_vec_t'((1 << IDX_OVF) | (1 << IDX_INX));
    localparam exc_vec_t PAIR_UNF = exc_vec_t'((1 << IDX_UNF) | (1 << IDX_INX));

    // True when the vector is one of the permitted exception patterns.
    function automatic logic legal_combo(exc_vec_t e);
        return ($countones(e) <= 1) || (e == PAIR_OVF) || (e == PAIR_UNF);
    endfunction
endpackage

// File: rtl/fpx_prio.sv
// Module fpx_prio
// Picks the single exception a trap reports from the vector of trapped
// exceptions: the highest bit index wins, so overflow and underflow
// outrank inexact. Also flags when inexact must be folded into the
// accrued register because a higher trap took precedence.
// Assumes the trapped vector already respects the coincidence rule.
module fpx_prio
    import fpx_pkg::*;
(
    input  exc_vec_t            trapped,
    input  logic                inx_raised,
    output exc_vec_t            pick_oh,
    output logic [CAUSE_W-1:0]  pick_cause,
    output logic                fold_inx
);
    // Scan upward so the last set bit (highest rank) is kept.
    always_comb begin
        pick_oh    = '0;
        pick_cause = '0;
        for (int i = 0; i < NEXC; i++) begin
            if (trapped[i]) begin
                pick_oh    = '0;
                pick_oh[i] = 1'b1;
                pick_cause = CAUSE_W'(i + 1);
            end
        end
    end

    // Inexact is recorded as accrued when overflow or underflow trapped.
    always_comb begin
        fold_inx = inx_raised & (pick_oh[IDX_OVF] | pick_oh[IDX_UNF]);
    end
endmodule

// File: rtl/fpx_flag_regs.sv
// Module fpx_flag_regs
// Holds the accrued, actual and trap-enable registers. A software write
// to a register takes priority over an operation update to that same
// register in the same cycle. Synchronous active-low reset clears all.
module fpx_flag_regs
    import fpx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  exc_vec_t         acc_set,
    input  logic             act_load,
    input  exc_vec_t         act_val,
    input  logic             sw_wr,
    input  logic [SEL_W-1:0] sw_sel,
    input  exc_vec_t         sw_data,
    output exc_vec_t         accrued_q,
    output exc_vec_t         actual_q,
    output exc_vec_t         enable_q
);
    logic wr_acc, wr_act, wr_en;

    // Decode the software write target.
    always_comb begin
        wr_acc = sw_wr && (sw_sel == SEL_ACC);
        wr_act = sw_wr && (sw_sel == SEL_ACT);
        wr_en  = sw_wr && (sw_sel == SEL_EN);
    end

    // Sticky accrued flags: software load, else OR in new flags.
    always_ff @(posedge clk) begin
        if (!rst_n)       accrued_q <= '0;
        else if (wr_acc)  accrued_q <= sw_data;
        else if (upd_en)  accrued_q <= accrued_q | acc_set;
    end

    // Actual flags: software load, else replace on a trapping operation.
    always_ff @(posedge clk) begin
        if (!rst_n)                  actual_q <= '0;
        else if (wr_act)             actual_q <= sw_data;
        else if (upd_en && act_load) actual_q <= act_val;
    end

    // Trap enables change only under software control.
    always_ff @(posedge clk) begin
        if (!rst_n)     enable_q <= '0;
        else if (wr_en) enable_q <= sw_data;
    end

    // R1: without a software load, accrued bits never clear.
    p_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_acc)) |->
            ((accrued_q & $past(accrued_q)) == $past(accrued_q)));

    // R7: enable register holds unless software targets it.
    p_enable_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en)) |-> $stable(enable_q));
endmodule

// File: rtl/fpx_flag_ctrl.sv
// Module fpx_flag_ctrl (top)
// Splits each operation's exceptions into untrapped (accrued, sticky)
// and trapped (actual, replaced) parts, suppresses the destination write
// in the operation cycle, and issues a registered trap request with a
// cause code one cycle later. Assumes op_exc obeys the coincidence rule.
module fpx_flag_ctrl
    import fpx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [NEXC-1:0]     op_exc,
    input  logic                sw_wr_en,
    input  logic [SEL_W-1:0]    sw_sel,
    input  logic [NEXC-1:0]     sw_wdata,
    output logic [NEXC-1:0]     accrued_q,
    output logic [NEXC-1:0]     actual_q,
    output logic [NEXC-1:0]     trap_en_q,
    output logic                dest_wr_suppress,
    output logic                trap_req,
    output logic [CAUSE_W-1:0]  trap_cause
);
    exc_vec_t           trapped, untrapped, pick_oh, acc_set;
    logic [CAUSE_W-1:0] pick_cause;
    logic               fold_inx, any_trap;

    // Split the valid operation's exceptions by their enable bits.
    always_comb begin
        trapped   = op_valid ? (op_exc & trap_en_q)  : '0;
        untrapped = op_valid ? (op_exc & ~trap_en_q) : '0;
        any_trap  = |trapped;
    end

    fpx_prio u_prio (
        .trapped    (trapped),
        .inx_raised (op_valid & op_exc[IDX_INX]),
        .pick_oh    (pick_oh),
        .pick_cause (pick_cause),
        .fold_inx   (fold_inx)
    );

    // Accrued gets untrapped flags plus a folded inexact.
    always_comb begin
        acc_set          = untrapped;
        acc_set[IDX_INX] = untrapped[IDX_INX] | fold_inx;
        dest_wr_suppress = any_trap;
    end

    fpx_flag_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (op_valid),
        .acc_set   (acc_set),
        .act_load  (any_trap),
        .act_val   (pick_oh),
        .sw_wr     (sw_wr_en),
        .sw_sel    (sw_sel),
        .sw_data   (sw_wdata),
        .accrued_q (accrued_q),
        .actual_q  (actual_q),
        .enable_q  (trap_en_q)
    );

    // Register the trap request and its cause for the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_req   <= 1'b0;
            trap_cause <= '0;
        end else begin
            trap_req   <= any_trap;
            trap_cause <= pick_cause;
        end
    end

    // R4: only permitted exception patterns arrive.
    p_legal_combo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> legal_combo(op_exc));

    // R3: a suppressed write is always followed by a trap request.
    p_supp_then_trap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dest_wr_suppress |=> trap_req);

    // R6: a trap request carries a code in the valid range.
    p_cause_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> ((trap_cause >= CAUSE_W'(1)) && (trap_cause <= CAUSE_W'(NEXC))));

    // R5: enabled overflow/underflow with inexact reports the higher one.
    p_prio_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_exc[IDX_INX] &&
         ((op_exc[IDX_OVF] && trap_en_q[IDX_OVF]) ||
          (op_exc[IDX_UNF] && trap_en_q[IDX_UNF])))
        |=> ((trap_cause == CAUSE_W'(IDX_OVF + 1)) ||
             (trap_cause == CAUSE_W'(IDX_UNF + 1))) && accrued_q[IDX_INX]);

    // R2: after a trap, actual flags are one-hot on the reported bit.
    p_actual_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && trap_req && !$past(sw_wr_en && (sw_sel == SEL_ACT)))
        |-> ($onehot(actual_q) &&
             (((actual_q >> (trap_cause - CAUSE_W'(1))) & exc_vec_t'(1)) != '0)));
endmodule

// File: tb/fpx_flag_ctrl_tb_top.sv
// Directed bench for fpx_flag_ctrl: one task per scenario.
module fpx_flag_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       op_valid;
    logic [4:0] op_exc;
    logic       sw_wr_en;
    logic [1:0] sw_sel;
    logic [4:0] sw_wdata;
    logic [4:0] accrued_q, actual_q, trap_en_q;
    logic       dest_wr_suppress, trap_req;
    logic [2:0] trap_cause;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    localparam logic [4:0] INX = 5'b00001, UNF = 5'b00010, OVF = 5'b00100,
                           DZ  = 5'b01000, INV = 5'b10000;

    always #5 clk = ~clk;

    fpx_flag_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_exc(op_exc),
        .sw_wr_en(sw_wr_en), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
        .accrued_q(accrued_q), .actual_q(actual_q), .trap_en_q(trap_en_q),
        .dest_wr_suppress(dest_wr_suppress), .trap_req(trap_req),
        .trap_cause(trap_cause)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic sw_write(input logic [1:0] sel, input logic [4:0] d);
        @(negedge clk);
        sw_wr_en = 1'b1; sw_sel = sel; sw_wdata = d;
        @(negedge clk);
        sw_wr_en = 1'b0;
    endtask

    // Drive one operation; check suppress in-cycle, then the registered results.
    task automatic do_op(input string req, input logic [4:0] e, input logic exp_supp,
                         input logic [4:0] exp_acc, input logic [4:0] exp_act,
                         input logic exp_trap, input logic [2:0] exp_cause);
        @(negedge clk);
        op_valid = 1'b1; op_exc = e;
        #1 chk(req, "dest_wr_suppress", {7'd0, dest_wr_suppress}, {7'd0, exp_supp});
        @(negedge clk);
        op_valid = 1'b0; op_exc = '0;
        chk(req, "accrued", {3'd0, accrued_q}, {3'd0, exp_acc});
        chk(req, "actual",  {3'd0, actual_q},  {3'd0, exp_act});
        chk(req, "trap_req", {7'd0, trap_req}, {7'd0, exp_trap});
        chk(req, "trap_cause", {5'd0, trap_cause}, {5'd0, exp_cause});
    endtask

    task automatic t_reset();
        chk("R8", "accrued reset", {3'd0, accrued_q}, 8'd0);
        chk("R8", "actual reset",  {3'd0, actual_q}, 8'd0);
        chk("R8", "enable reset",  {3'd0, trap_en_q}, 8'd0);
        chk("R8", "trap_req reset", {7'd0, trap_req}, 8'd0);
        chk("R8", "cause reset", {5'd0, trap_cause}, 8'd0);
    endtask

    task automatic t_untrapped();
        do_op("R1", DZ,  1'b0, DZ,       5'd0, 1'b0, 3'd0);
        do_op("R1", INX, 1'b0, DZ | INX, 5'd0, 1'b0, 3'd0);
    endtask

    task automatic t_trap_invalid();
        sw_write(2'd2, INV | OVF | UNF);
        chk("R7", "enable write", {3'd0, trap_en_q}, {3'd0, INV | OVF | UNF});
        do_op("R2", INV, 1'b1, DZ | INX, INV, 1'b1, 3'd5);
        @(negedge clk);
        chk("R6", "trap_req one cycle", {7'd0, trap_req}, 8'd0);
    endtask

    task automatic t_prio();
        sw_write(2'd0, 5'd0);
        chk("R7", "accrued cleared", {3'd0, accrued_q}, 8'd0);
        do_op("R5", OVF | INX, 1'b1, INX, OVF, 1'b1, 3'd3);
        sw_write(2'd2, INV | OVF | UNF | INX);
        sw_write(2'd0, 5'd0);
        do_op("R5", UNF | INX, 1'b1, INX, UNF, 1'b1, 3'd2);
    endtask

    task automatic t_inexact_only_enabled();
        sw_write(2'd2, INX);
        sw_write(2'd0, 5'd0);
        do_op("R2", OVF | INX, 1'b1, OVF, INX, 1'b1, 3'd1);
    endtask

    task automatic t_ignored();
        do_op("R10", 5'd0, 1'b0, OVF, INX, 1'b0, 3'd0);
        @(negedge clk);
        op_valid = 1'b0; op_exc = INV | DZ;
        #1 chk("R9", "suppress idle", {7'd0, dest_wr_suppress}, 8'd0);
        @(negedge clk);
        op_exc = '0;
        chk("R9", "accrued idle", {3'd0, accrued_q}, {3'd0, OVF});
        chk("R9", "actual idle", {3'd0, actual_q}, {3'd0, INX});
        chk("R9", "trap_req idle", {7'd0, trap_req}, 8'd0);
    endtask

    task automatic t_sw_priority();
        @(negedge clk);
        sw_wr_en = 1'b1; sw_sel = 2'd0; sw_wdata = INV;
        op_valid = 1'b1; op_exc = DZ;
        @(negedge clk);
        sw_wr_en = 1'b0; op_valid = 1'b0; op_exc = '0;
        chk("R7", "write beats update", {3'd0, accrued_q}, {3'd0, INV});
        sw_write(2'd3, 5'b11111);
        chk("R7", "sel 3 accrued", {3'd0, accrued_q}, {3'd0, INV});
        chk("R7", "sel 3 actual", {3'd0, actual_q}, {3'd0, INX});
        chk("R7", "sel 3 enable", {3'd0, trap_en_q}, {3'd0, INX});
        sw_write(2'd1, DZ);
        chk("R7", "actual write", {3'd0, actual_q}, {3'd0, DZ});
    endtask

    task automatic t_reset_again();
        @(negedge clk);
        rst_n = 1'b0; op_valid = 1'b1; op_exc = INX;
        @(negedge clk);
        rst_n = 1'b1; op_valid = 1'b0; op_exc = '0;
        t_reset();
    endtask

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; op_exc = '0;
        sw_wr_en = 1'b0; sw_sel = '0; sw_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_untrapped();
        t_trap_invalid();
        t_prio();
        t_inexact_only_enabled();
        t_ignored();
        t_sw_priority();
        t_reset_again();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule